// File: doc/BRIEF.md
# Ternary Match Table with Command Port

This block holds a small ternary lookup table. Each entry stores a data word, a mask word and a valid bit. A single command port drives it. The port is an 11-bit command word with a valid strobe and a shared data bus. Depending on the opcode, that bus carries a start address, array words, or a search key. Software-style reads and writes reach the data array, the mask array and a control register. They can run as bursts of up to eight words at consecutive addresses.

A search compares the key against every valid entry in parallel. It reports whether any entry matched, the lowest matching index, and whether more than one entry matched. A learn places the key into the lowest free entry as an exact-match entry.

The control register is a global mask. Key bits set in it are ignored by every entry during searches. A host uses the block by loading entries and masks through write bursts, checking them through read bursts, and then issuing searches back to back, one per cycle.

Top module: `tcam_cmd_engine`

## Requirements
- R1: After reset, every entry is invalid and the global mask is zero. The outputs ack_o, eot_o, result_valid_o, hit_o, multi_hit_o and learn_err_o are all 0.
- R2: A cycle with cmd_valid_i = 0 is idle. Whatever is on cmd_i and dq_i in that cycle changes no table state and produces no acknowledge or result.
- R3: The command fields are: opcode cmd_i[1:0], target cmd_i[3:2], burst length minus one cmd_i[6:4], and a valid flag cmd_i[7]. A write (opcode 01) takes its start address from the low index bits of dq_i in the command cycle. It then takes one data word from dq_i in each of the following N cycles and stores them at consecutive addresses, wrapping modulo the entry count. A data-array write (target 00) also sets that entry's valid bit to cmd_i[7]. eot_o is 1 exactly in the cycle of the last word.
- R4: A read (opcode 00) uses the same fields. In each of the N cycles after the command, ack_o = 1 and dq_o carries the addressed word, with eot_o = 1 on the last one. In every other cycle ack_o = 0 and dq_o = 0.
- R5: Target 01 is the mask array. Target 10 is the global mask register, for which the address is ignored. Target 11 is reserved: writes to it change nothing and reads from it return zero.
- R6: A search (opcode 10) matches an entry when the entry is valid and the entry's data equals dq_i on every bit where neither the entry's mask nor the global mask has a 1.
- R7: hit_o shows whether any entry matched. hit_index_o is the lowest matching index, or 0 on a miss.
- R8: multi_hit_o is 1 exactly when two or more entries match.
- R9: A search issued in cycle c gives result_valid_o = 1 for one cycle, in cycle c+2. Searches may be issued in every cycle. hit_o, hit_index_o and multi_hit_o hold their values until the next result.
- R10: A learn (opcode 11) writes the key into the lowest-numbered invalid entry, with a zero mask, and sets that entry valid.
- R11: A learn issued when every entry is valid changes no entry. It raises learn_err_o for one cycle, in the cycle after the command.
- R12: While a read or write burst is in progress, cmd_valid_i and cmd_i are ignored. No search or learn starts, and the burst carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Qualifies cmd_i |
| cmd_i | input | 11 | Opcode and parameters |
| dq_i | input | WIDTH | Address, write data or search key |
| dq_o | output | WIDTH | Read data, zero when no acknowledge |
| ack_o | output | 1 | Read data present on dq_o |
| eot_o | output | 1 | Last word of a burst |
| result_valid_o | output | 1 | Search result pulse |
| hit_o | output | 1 | At least one entry matched |
| hit_index_o | output | $clog2(ENTRIES) | Lowest matching entry |
| multi_hit_o | output | 1 | More than one entry matched |
| learn_err_o | output | 1 | Learn refused, table full |

## Verification
Searches are tried with every possible key against a table built to contain several kinds of entry: exact entries, entries with don't-care nibbles, entries whose ranges overlap, and an invalid entry with an all-ones mask. This tells apart errors in the mask polarity, the valid gating, the priority order and the multiple-match count. The same sweep is repeated with a non-zero global mask, which tells apart a global mask that is applied from one that is dropped.

Bursts start at an address near the top of the table so that the address wrap is exercised. The reserved target and idle cycles are driven with busy-looking bus contents, and the result is read back through the normal read path. Learn is taken from a sparse table up to a full one, so that both the free-slot choice and the refusal path are observed.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    OP_RD    = 2'b00,
    OP_WR    = 2'b01,
    OP_SRCH  = 2'b10,
    OP_LEARN = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    TGT_DATA = 2'b00,
    TGT_MASK = 2'b01,
    TGT_CTRL = 2'b10,
    TGT_RSVD = 2'b11
  } tgt_e;

  localparam int LEN_W = 3;

  typedef struct packed {
    logic [2:0]       spare;
    logic             vflag;
    logic [LEN_W-1:0] len_m1;
    tgt_e             tgt;
    op_e              op;
  } cmd_t;
endpackage

// File: rtl/tcam_cmd_seq.sv
module tcam_cmd_seq
  import tcam_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  cmd_t             cmd_i,
  input  logic [IDX_W-1:0] addr_i,
  output logic             search_go_o,
  output logic             learn_go_o,
  output logic             xfer_rd_o,
  output logic             xfer_wr_o,
  output tgt_e             xfer_tgt_o,
  output logic [IDX_W-1:0] xfer_addr_o,
  output logic             xfer_vflag_o,
  output logic             eot_o
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2} st_e;

  st_e              st_q;
  logic [IDX_W-1:0] base_q;
  logic [LEN_W-1:0] cnt_q, last_q;
  tgt_e             tgt_q;
  logic             vflag_q;
  logic             accept;
  logic             start_xfer;

  assign accept      = cmd_valid_i && (st_q == S_IDLE);
  assign start_xfer  = accept && (cmd_i.op == OP_RD || cmd_i.op == OP_WR);
  assign search_go_o = accept && (cmd_i.op == OP_SRCH);
  assign learn_go_o  = accept && (cmd_i.op == OP_LEARN);

  assign eot_o        = (st_q != S_IDLE) && (cnt_q == last_q);
  assign xfer_rd_o    = (st_q == S_RD);
  assign xfer_wr_o    = (st_q == S_WR);
  assign xfer_tgt_o   = tgt_q;
  assign xfer_vflag_o = vflag_q;
  assign xfer_addr_o  = base_q + IDX_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      base_q  <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      tgt_q   <= TGT_DATA;
      vflag_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_xfer) begin
            st_q    <= (cmd_i.op == OP_RD) ? S_RD : S_WR;
            base_q  <= addr_i;
            cnt_q   <= '0;
            last_q  <= cmd_i.len_m1;
            tgt_q   <= cmd_i.tgt;
            vflag_q <= cmd_i.vflag;
          end
        end
        default: begin
          if (eot_o) st_q <= S_IDLE;
          else       cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  // R3
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eot_o |=> (st_q == S_IDLE));

  // R4
  read_ack_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_xfer && cmd_i.op == OP_RD) |=> xfer_rd_o);

  // R12
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE && !eot_o) |=> (st_q == $past(st_q) && base_q == $past(base_q)));
endmodule

// File: rtl/tcam_store.sv
module tcam_store
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 72,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  tgt_e                           tgt_i,
  input  logic [IDX_W-1:0]               addr_i,
  input  logic [WIDTH-1:0]               wdata_i,
  input  logic                           vflag_i,
  input  logic                           learn_go_i,
  input  logic [WIDTH-1:0]               key_i,
  output logic [WIDTH-1:0]               rdata_o,
  output logic [ENTRIES-1:0][WIDTH-1:0]  data_o,
  output logic [ENTRIES-1:0][WIDTH-1:0]  mask_o,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [WIDTH-1:0]               gmask_o,
  output logic                           learn_err_o
);
  logic [ENTRIES-1:0][WIDTH-1:0] data_q, mask_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [WIDTH-1:0]              gmask_q;
  logic                          err_q;
  logic                          full;
  logic [IDX_W-1:0]              free_idx;

  function automatic logic [IDX_W-1:0] lowest_one(input logic [ENTRIES-1:0] v);
    lowest_one = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) lowest_one = IDX_W'(i);
  endfunction

  assign full     = &valid_q;
  assign free_idx = lowest_one(~valid_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      mask_q  <= '0;
      valid_q <= '0;
      gmask_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= learn_go_i && full;
      if (wr_en_i) begin
        case (tgt_i)
          TGT_DATA: begin
            data_q[addr_i]  <= wdata_i;
            valid_q[addr_i] <= vflag_i;
          end
          TGT_MASK: mask_q[addr_i] <= wdata_i;
          TGT_CTRL: gmask_q <= wdata_i;
          default: ;
        endcase
      end else if (learn_go_i && !full) begin
        data_q[free_idx]  <= key_i;
        mask_q[free_idx]  <= '0;
        valid_q[free_idx] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (tgt_i)
      TGT_DATA: rdata_o = data_q[addr_i];
      TGT_MASK: rdata_o = mask_q[addr_i];
      TGT_CTRL: rdata_o = gmask_q;
      default:  rdata_o = '0;
    endcase
  end

  assign data_o      = data_q;
  assign mask_o      = mask_q;
  assign valid_o     = valid_q;
  assign gmask_o     = gmask_q;
  assign learn_err_o = err_q;

  // R11
  full_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_go_i && full) |=> (valid_q == $past(valid_q) && data_q == $past(data_q) && learn_err_o));

  // R10
  learn_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (learn_go_i && !full) |=> ($countones(valid_q) == $countones($past(valid_q)) + 1));
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 72,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          search_go_i,
  input  logic [WIDTH-1:0]              key_i,
  input  logic [ENTRIES-1:0][WIDTH-1:0] data_i,
  input  logic [ENTRIES-1:0][WIDTH-1:0] mask_i,
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [WIDTH-1:0]              gmask_i,
  output logic                          rvalid_o,
  output logic                          hit_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic                          multi_o
);
  logic               s1_q;
  logic [WIDTH-1:0]   key_q;
  logic [ENTRIES-1:0] hits;

  function automatic logic entry_hit(input logic [WIDTH-1:0] d, input logic [WIDTH-1:0] m,
                                     input logic [WIDTH-1:0] g, input logic [WIDTH-1:0] k);
    entry_hit = ((d ^ k) & ~(m | g)) == '0;
  endfunction

  function automatic logic several(input logic [ENTRIES-1:0] v);
    several = |(v & (v - 1'b1));
  endfunction

  function automatic logic [IDX_W-1:0] first_hit(input logic [ENTRIES-1:0] v);
    first_hit = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) first_hit = IDX_W'(i);
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign hits[e] = valid_i[e] && entry_hit(data_i[e], mask_i[e], gmask_i, key_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q     <= 1'b0;
      key_q    <= '0;
      rvalid_o <= 1'b0;
      hit_o    <= 1'b0;
      idx_o    <= '0;
      multi_o  <= 1'b0;
    end else begin
      s1_q     <= search_go_i;
      rvalid_o <= s1_q;
      if (search_go_i) key_q <= key_i;
      if (s1_q) begin
        hit_o   <= |hits;
        idx_o   <= first_hit(hits);
        multi_o <= several(hits);
      end
    end
  end

  // R9
  result_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    search_go_i |=> ##1 rvalid_o);

  // R9
  result_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> $past(search_go_i, 2));

  // R8
  multi_implies_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_o |-> hit_o);
endmodule

// File: rtl/tcam_cmd_engine.sv
module tcam_cmd_engine
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int WIDTH   = 72,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [10:0]      cmd_i,
  input  logic [WIDTH-1:0] dq_i,
  output logic [WIDTH-1:0] dq_o,
  output logic             ack_o,
  output logic             eot_o,
  output logic             result_valid_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_index_o,
  output logic             multi_hit_o,
  output logic             learn_err_o
);
  cmd_t                          cmd_f;
  logic                          search_go, learn_go, xfer_rd, xfer_wr, xfer_vflag;
  tgt_e                          xfer_tgt;
  logic [IDX_W-1:0]              xfer_addr;
  logic [WIDTH-1:0]              rdata, gmask;
  logic [ENTRIES-1:0][WIDTH-1:0] data_arr, mask_arr;
  logic [ENTRIES-1:0]            valid_vec;

  assign cmd_f = cmd_t'(cmd_i);

  tcam_cmd_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_f),
    .addr_i(dq_i[IDX_W-1:0]), .search_go_o(search_go), .learn_go_o(learn_go),
    .xfer_rd_o(xfer_rd), .xfer_wr_o(xfer_wr), .xfer_tgt_o(xfer_tgt),
    .xfer_addr_o(xfer_addr), .xfer_vflag_o(xfer_vflag), .eot_o(eot_o)
  );

  tcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(xfer_wr), .tgt_i(xfer_tgt),
    .addr_i(xfer_addr), .wdata_i(dq_i), .vflag_i(xfer_vflag),
    .learn_go_i(learn_go), .key_i(dq_i), .rdata_o(rdata),
    .data_o(data_arr), .mask_o(mask_arr), .valid_o(valid_vec),
    .gmask_o(gmask), .learn_err_o(learn_err_o)
  );

  tcam_lookup #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .search_go_i(search_go), .key_i(dq_i),
    .data_i(data_arr), .mask_i(mask_arr), .valid_i(valid_vec), .gmask_i(gmask),
    .rvalid_o(result_valid_o), .hit_o(hit_o), .idx_o(hit_index_o),
    .multi_o(multi_hit_o)
  );

  assign ack_o = xfer_rd;
  assign dq_o  = xfer_rd ? rdata : '0;

  // R4
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (dq_o == '0));

  // R2
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid_i && !result_valid_o) |=> ##1 !result_valid_o);
endmodule

// File: tb/tcam_cmd_engine_test.sv
module tcam_cmd_engine_test;
  localparam int E  = 8;
  localparam int W  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [10:0]   cmd = '0;
  logic [W-1:0]  dq_in = '0;
  logic [W-1:0]  dq_out;
  logic          ack, eot, rvalid, hit, multi, lerr;
  logic [IW-1:0] hidx;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] md [E];
  logic [W-1:0] mm [E];
  logic         mv [E];
  logic [W-1:0] mg;
  logic [W-1:0] wbuf [8];

  always #2 clk = ~clk;

  tcam_cmd_engine #(.ENTRIES(E), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .dq_i(dq_in),
    .dq_o(dq_out), .ack_o(ack), .eot_o(eot), .result_valid_o(rvalid), .hit_o(hit),
    .hit_index_o(hidx), .multi_hit_o(multi), .learn_err_o(lerr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] mkcmd(input logic [1:0] op, input logic [1:0] tgt,
                                        input int n, input bit vf);
    mkcmd = {3'b000, vf, 3'(n - 1), tgt, op};
  endfunction

  function automatic logic [W-1:0] model_read(input logic [1:0] tgt, input int a);
    case (tgt)
      2'b00:   model_read = md[a];
      2'b01:   model_read = mm[a];
      2'b10:   model_read = mg;
      default: model_read = '0;
    endcase
  endfunction

  task automatic msearch(input logic [W-1:0] k, output bit h, output int idx, output bit mul);
    int cnt;
    bit ok;
    cnt = 0; idx = 0;
    for (int e = 0; e < E; e++) begin
      ok = mv[e];
      for (int b = 0; b < W; b++)
        if (!mm[e][b] && !mg[b] && (md[e][b] != k[b])) ok = 1'b0;
      if (ok) begin
        if (cnt == 0) idx = e;
        cnt++;
      end
    end
    h = (cnt > 0);
    mul = (cnt > 1);
  endtask

  task automatic do_write(input logic [1:0] tgt, input int addr, input int n,
                          input bit vf, input bit noise);
    int a;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = mkcmd(2'b01, tgt, n, vf); dq_in = W'(addr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(eot == (k == n - 1), "R3", "eot during write", 32'(eot), 32'(k == n - 1));
      cmd_valid = noise;
      cmd = (k % 2 == 0) ? mkcmd(2'b10, 2'b00, 1, 1'b0) : mkcmd(2'b11, 2'b00, 1, 1'b0);
      dq_in = wbuf[k];
      a = (addr + k) % E;
      case (tgt)
        2'b00: begin md[a] = wbuf[k]; mv[a] = vf; end
        2'b01: mm[a] = wbuf[k];
        2'b10: mg = wbuf[k];
        default: ;
      endcase
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd = '0; dq_in = '0;
  endtask

  task automatic do_read(input logic [1:0] tgt, input int addr, input int n, input string req);
    logic [W-1:0] exp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = mkcmd(2'b00, tgt, n, 1'b0); dq_in = W'(addr);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0; dq_in = '0;
      exp = model_read(tgt, (addr + k) % E);
      chk(ack && dq_out == exp, req, "read word", 32'(dq_out), 32'(exp));
      chk(eot == (k == n - 1), "R4", "eot during read", 32'(eot), 32'(k == n - 1));
    end
    @(negedge clk);
    chk(!ack && dq_out == '0, "R4", "ack after burst", 32'(ack), 32'(0));
  endtask

  task automatic search_one(input logic [W-1:0] key, input string req);
    bit eh, em;
    int ei;
    msearch(key, eh, ei, em);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = mkcmd(2'b10, 2'b00, 1, 1'b0); dq_in = key;
    @(negedge clk);
    cmd_valid = 1'b0; dq_in = '0;
    chk(!rvalid, "R9", "result too early", 32'(rvalid), 32'(0));
    @(negedge clk);
    chk(rvalid, "R9", "result at c+2", 32'(rvalid), 32'(1));
    chk(hit == eh && hidx == IW'(ei) && multi == em, req, "single search",
        {hit, multi, 27'(hidx)}, {eh, em, 27'(ei)});
    @(negedge clk);
    chk(!rvalid, "R9", "result pulse width", 32'(rvalid), 32'(0));
  endtask

  task automatic learn_one(input logic [W-1:0] key);
    int slot;
    slot = -1;
    for (int e = E - 1; e >= 0; e--) if (!mv[e]) slot = e;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = mkcmd(2'b11, 2'b00, 1, 1'b0); dq_in = key;
    @(negedge clk);
    cmd_valid = 1'b0; dq_in = '0;
    if (slot < 0) begin
      chk(lerr, "R11", "learn error on full table", 32'(lerr), 32'(1));
      @(negedge clk);
      chk(!lerr, "R11", "learn error pulse width", 32'(lerr), 32'(0));
    end else begin
      chk(!lerr, "R10", "no learn error", 32'(lerr), 32'(0));
      md[slot] = key; mm[slot] = '0; mv[slot] = 1'b1;
    end
  endtask

  task automatic sweep(input string tag);
    bit eh, em;
    int ei;
    for (int k = 0; k < 258; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        msearch(W'(k - 2), eh, ei, em);
        chk(rvalid, "R9", {"sweep valid ", tag}, 32'(rvalid), 32'(1));
        chk(hit == eh, "R6", {"sweep hit ", tag}, 32'(hit), 32'(eh));
        chk(hidx == IW'(ei), "R7", {"sweep index ", tag}, 32'(hidx), 32'(ei));
        chk(multi == em, "R8", {"sweep multi ", tag}, 32'(multi), 32'(em));
      end
      if (k < 256) begin
        cmd_valid = 1'b1; cmd = mkcmd(2'b10, 2'b00, 1, 1'b0); dq_in = W'(k);
      end else begin
        cmd_valid = 1'b0; dq_in = '0;
      end
    end
    @(negedge clk);
    chk(!rvalid, "R9", "no result after sweep", 32'(rvalid), 32'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < E; e++) begin md[e] = '0; mm[e] = '0; mv[e] = 1'b0; end
    mg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!ack && !eot && !rvalid && !hit && !multi && !lerr, "R1", "outputs after reset",
        {ack, eot, rvalid, hit, multi, lerr}, 32'(0));
    search_one(8'h00, "R1");

    // R2: idle cycles with busy-looking bus contents
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd = (k % 2 == 0) ? mkcmd(2'b01, 2'b00, 1, 1'b1) : mkcmd(2'b11, 2'b00, 1, 1'b0);
      dq_in = W'(8'h5A + k);
      chk(!ack && !rvalid && !lerr, "R2", "idle cycle quiet", {ack, rvalid, lerr}, 32'(0));
    end
    cmd = '0;
    do_read(2'b00, 0, 8, "R2");
    search_one(8'h5B, "R2");

    // R3: data burst starting at 3, wrapping
    for (int k = 0; k < 8; k++) wbuf[k] = W'(((3 + k) % E) * 37 + 11);
    do_write(2'b00, 3, 8, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      case ((3 + k) % E)
        6:       wbuf[k] = 8'hFF;
        default: wbuf[k] = (((3 + k) % E) % 3 == 0) ? 8'h00 :
                           (((3 + k) % E) % 3 == 1) ? 8'h0F : 8'h30;
      endcase
    end
    do_write(2'b01, 3, 8, 1'b0, 1'b0);
    wbuf[0] = md[6];
    do_write(2'b00, 6, 1, 1'b0, 1'b0);
    // R4: read bursts
    do_read(2'b00, 5, 8, "R4");
    do_read(2'b01, 0, 8, "R3");

    // R6 R7 R8 R9: full key sweep
    sweep("plain");

    // R5: global mask
    wbuf[0] = 8'hC0;
    do_write(2'b10, 5, 1, 1'b0, 1'b0);
    do_read(2'b10, 1, 1, "R5");
    sweep("gmask");
    // R5: reserved target
    wbuf[0] = 8'hA5;
    do_write(2'b11, 2, 1, 1'b1, 1'b0);
    do_read(2'b11, 2, 1, "R5");
    do_read(2'b00, 0, 8, "R5");
    do_read(2'b10, 0, 1, "R5");
    wbuf[0] = 8'h00;
    do_write(2'b10, 0, 1, 1'b0, 1'b0);

    // R12: commands during a burst are ignored
    for (int k = 0; k < 4; k++) wbuf[k] = W'(8'hE0 + k);
    do_write(2'b00, 0, 4, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!rvalid && !lerr, "R12", "no search or learn from burst", {rvalid, lerr}, 32'(0));
    end
    do_read(2'b00, 0, 8, "R12");
    do_read(2'b01, 0, 8, "R12");

    // R10: learn into a sparse table
    for (int k = 0; k < 8; k++) wbuf[k] = '0;
    do_write(2'b00, 0, 8, 1'b0, 1'b0);
    wbuf[0] = 8'h10; do_write(2'b00, 0, 1, 1'b1, 1'b0);
    wbuf[0] = 8'h11; do_write(2'b00, 1, 1, 1'b1, 1'b0);
    wbuf[0] = 8'h13; do_write(2'b00, 3, 1, 1'b1, 1'b0);
    learn_one(8'h77);
    do_read(2'b00, 2, 1, "R10");
    do_read(2'b01, 2, 1, "R10");
    search_one(8'h77, "R10");
    for (int k = 0; k < 4; k++) learn_one(W'(8'h80 + k));
    do_read(2'b00, 0, 8, "R10");
    do_read(2'b01, 0, 8, "R10");
    // R11: learn on a full table
    learn_one(8'h99);
    do_read(2'b00, 0, 8, "R11");
    search_one(8'h99, "R11");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule